// File: doc/BRIEF.md
# Multi-Lane Link Sync Qualifier

This block watches the code-group synchronization phase that each of several receive lanes reports and decides when the link as a whole is synchronized. The link counts as synchronized only after every lane has reported the data phase on an unbroken run of clock edges of a set length. A single edge on which any lane drops out of the data phase restarts the run. Once the link is synchronized it stays synchronized until software disables the link or issues a software reset. The lanes' phases have no effect on it after that point.

Beside the decision, the block keeps two saturating error counters per lane: one for frame-alignment errors and one for disparity errors. Alignment errors count only while their lane is in the data phase, because a lane that is out of sync sees random input. No event counts while the link is disabled or held in software reset. Errors seen while the link is being brought up are irrelevant once it is synchronized, so both sets of counters are cleared on the edge where the link becomes synchronized. Errors after that point are kept.

A three-state machine controls the link:
- DISABLED: the link is off, or software reset is active.
- QUALIFY: the link is enabled and the run of all-data edges is being counted.
- SYNCED: the link is synchronized.

Transitions:
- enable: DISABLED to QUALIFY, when the link is enabled and software reset is low.
- lock: QUALIFY to SYNCED, on the last edge of the qualifying run.
- drop: QUALIFY or SYNCED to DISABLED, when the link is disabled or software reset is raised.

Top module: `link_sync_qual`

## Requirements
- R1: Lane i reports its phase on `lane_phase[2i+1:2i]`: 0 = INIT, 1 = CHECK, 2 = DATA. The code 3 counts as not in the data phase.
- R2: After reset, `link_synced` is 0 and every error counter reads 0.
- R3: With the block in QUALIFY, `link_synced` rises immediately after the QUAL_CYCLES-th consecutive clock edge on which every lane reports DATA. It is still 0 after QUAL_CYCLES-1 such edges.
- R4: Any edge on which a lane is not in DATA during the run restarts the count from zero. The link then needs a full fresh run of QUAL_CYCLES edges.
- R5: Once `link_synced` is 1, it stays 1 whatever the lane phases are, as long as `link_en` is 1 and `sw_reset` is 0.
- R6: An edge with `link_en` at 0 or `sw_reset` at 1 returns the block to DISABLED: `link_synced` is 0 after that edge and the qualifying count is cleared. The next enabled edge enters QUALIFY without counting.
- R7: On the edge where the link becomes synchronized, every alignment and disparity counter is cleared to 0.
- R8: An alignment error on lane i is counted only on edges where lane i reports DATA. A disparity error is counted in any phase.
- R9: While `link_en` is 0, error events change no counter.
- R10: Each counter saturates at 2^ERR_W-1 and does not wrap.
- R11: An edge with `sw_reset` at 1 clears every error counter.
- R12: Errors counted after the link is synchronized accumulate and are kept.
- Counter i occupies bits `[i*ERR_W +: ERR_W]` of `align_cnt` and of `disp_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en | input | 1 | Link enable from software |
| sw_reset | input | 1 | Software reset of link state and counters |
| lane_phase | input | 2*NUM_LANES | Per-lane synchronization phase, 2 bits per lane |
| align_err | input | NUM_LANES | Per-lane frame-alignment error event |
| disp_err | input | NUM_LANES | Per-lane disparity error event |
| link_synced | output | 1 | Link is synchronized |
| align_cnt | output | NUM_LANES*ERR_W | Packed per-lane alignment error counters |
| disp_cnt | output | NUM_LANES*ERR_W | Packed per-lane disparity error counters |

## Verification
The bench builds the block with NUM_LANES = 3 and ERR_W = 4, and keeps the default QUAL_CYCLES of 256. The full qualifying window is therefore checked at the edge before it completes and at the edge where it completes, using the same 9-bit count a real link uses. With three lanes, one lane can drop out of the data phase while the others remain in it, which tests whether the run restarts. The 4-bit counters reach saturation within a few cycles of stimulus.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        PH_INIT  = 2'd0,
        PH_CHECK = 2'd1,
        PH_DATA  = 2'd2
    } lane_phase_t;

    typedef enum logic [1:0] {
        LS_DISABLED = 2'd0,
        LS_QUALIFY  = 2'd1,
        LS_SYNCED   = 2'd2
    } link_state_t;

endpackage

// File: rtl/lsq_lane_decode.sv
module lsq_lane_decode #(
    parameter int NUM_LANES = 4
) (
    input  logic [2*NUM_LANES-1:0] lane_phase,
    output logic [NUM_LANES-1:0]   lane_in_data,
    output logic                   all_in_data
);
    import lsq_pkg::*;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_in_data[g] = (lane_phase[2*g +: 2] == PH_DATA);
    end

    assign all_in_data = &lane_in_data;

endmodule

// File: rtl/lsq_link_fsm.sv
module lsq_link_fsm #(
    parameter int QUAL_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_en,
    input  logic sw_reset,
    input  logic all_in_data,
    output logic link_synced,
    output logic lock_entry
);
    import lsq_pkg::*;

    localparam int QCNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [QCNT_W-1:0] QUAL_LAST = QCNT_W'(QUAL_CYCLES - 1);

    link_state_t       state_q, state_d;
    logic [QCNT_W-1:0] qual_cnt_q;
    logic              go;
    logic              run_ok;

    assign go     = link_en && !sw_reset;
    assign run_ok = (state_q == LS_QUALIFY) && go && all_in_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LS_DISABLED;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_DISABLED: begin
                if (go) state_d = LS_QUALIFY;
            end
            LS_QUALIFY: begin
                if (!go) begin
                    state_d = LS_DISABLED;
                end else if (all_in_data && qual_cnt_q == QUAL_LAST) begin
                    state_d = LS_SYNCED;
                end
            end
            LS_SYNCED: begin
                if (!go) state_d = LS_DISABLED;
            end
            default: state_d = LS_DISABLED;
        endcase
    end

    // qualifying run counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_cnt_q <= '0;
        end else if (run_ok && qual_cnt_q != QUAL_LAST) begin
            qual_cnt_q <= qual_cnt_q + 1'b1;
        end else begin
            qual_cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        link_synced = (state_q == LS_SYNCED);
        lock_entry  = run_ok && (qual_cnt_q == QUAL_LAST);
    end

endmodule

// File: rtl/lsq_sat_counter.sv
module lsq_sat_counter #(
    parameter int ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/link_sync_qual.sv
module link_sync_qual #(
    parameter int NUM_LANES   = 4,
    parameter int QUAL_CYCLES = 256,
    parameter int ERR_W       = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       link_en,
    input  logic                       sw_reset,
    input  logic [2*NUM_LANES-1:0]     lane_phase,
    input  logic [NUM_LANES-1:0]       align_err,
    input  logic [NUM_LANES-1:0]       disp_err,
    output logic                       link_synced,
    output logic [NUM_LANES*ERR_W-1:0] align_cnt,
    output logic [NUM_LANES*ERR_W-1:0] disp_cnt
);

    logic [NUM_LANES-1:0] lane_in_data;
    logic                 all_in_data;
    logic                 lock_entry;
    logic                 count_en;
    logic                 cnt_clear;

    assign count_en  = link_en && !sw_reset;
    assign cnt_clear = sw_reset || lock_entry;

    lsq_lane_decode #(
        .NUM_LANES (NUM_LANES)
    ) u_decode (
        .lane_phase   (lane_phase),
        .lane_in_data (lane_in_data),
        .all_in_data  (all_in_data)
    );

    lsq_link_fsm #(
        .QUAL_CYCLES (QUAL_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_en     (link_en),
        .sw_reset    (sw_reset),
        .all_in_data (all_in_data),
        .link_synced (link_synced),
        .lock_entry  (lock_entry)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_err
        lsq_sat_counter #(
            .ERR_W (ERR_W)
        ) u_align (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (cnt_clear),
            .inc   (count_en && align_err[g] && lane_in_data[g]),
            .count (align_cnt[g*ERR_W +: ERR_W])
        );

        lsq_sat_counter #(
            .ERR_W (ERR_W)
        ) u_disp (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (cnt_clear),
            .inc   (count_en && disp_err[g]),
            .count (disp_cnt[g*ERR_W +: ERR_W])
        );
    end

endmodule

// File: rtl/link_sync_qual_checker.sv
module link_sync_qual_checker #(
    parameter int NUM_LANES   = 4,
    parameter int QUAL_CYCLES = 256,
    parameter int ERR_W       = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       link_en,
    input logic                       sw_reset,
    input logic [2*NUM_LANES-1:0]     lane_phase,
    input logic [NUM_LANES*ERR_W-1:0] align_cnt,
    input logic [NUM_LANES*ERR_W-1:0] disp_cnt,
    input logic                       link_synced
);
    localparam int RUN_W = $clog2(QUAL_CYCLES + 1);

    logic             all_data;
    logic [RUN_W-1:0] run_q;

    always_comb begin
        all_data = 1'b1;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (lane_phase[2*i +: 2] != 2'd2) all_data = 1'b0;
        end
    end

    // independent count of consecutive enabled all-data edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!(all_data && link_en && !sw_reset)) begin
            run_q <= '0;
        end else if (run_q != RUN_W'(QUAL_CYCLES)) begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_synced) |-> run_q >= RUN_W'(QUAL_CYCLES)); // R4

    AST_LOCK_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_synced) |-> $past(all_data)); // R3

    AST_SYNC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (link_synced && link_en && !sw_reset) |=> link_synced); // R5

    AST_DROP_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en || sw_reset) |=> !link_synced); // R6

    AST_CLEAR_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_synced) |-> (align_cnt == '0 && disp_cnt == '0)); // R7

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_en && !sw_reset) |=> ($stable(align_cnt) && $stable(disp_cnt))); // R9

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_chk
        AST_ALIGN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (link_en && !sw_reset && lane_phase[2*g +: 2] != 2'd2)
            |=> $stable(align_cnt[g*ERR_W +: ERR_W])); // R8
    end

endmodule

bind link_sync_qual link_sync_qual_checker #(
    .NUM_LANES   (NUM_LANES),
    .QUAL_CYCLES (QUAL_CYCLES),
    .ERR_W       (ERR_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_en     (link_en),
    .sw_reset    (sw_reset),
    .lane_phase  (lane_phase),
    .align_cnt   (align_cnt),
    .disp_cnt    (disp_cnt),
    .link_synced (link_synced)
);

// File: tb/link_sync_qual_tb.sv
module link_sync_qual_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int QC         = 256;
    localparam int EW         = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              link_en;
    logic              sw_reset;
    logic [2*NL-1:0]   lane_phase;
    logic [NL-1:0]     align_err;
    logic [NL-1:0]     disp_err;
    logic              link_synced;
    logic [NL*EW-1:0]  align_cnt;
    logic [NL*EW-1:0]  disp_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    link_sync_qual #(
        .NUM_LANES   (NL),
        .QUAL_CYCLES (QC),
        .ERR_W       (EW)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_en     (link_en),
        .sw_reset    (sw_reset),
        .lane_phase  (lane_phase),
        .align_err   (align_err),
        .disp_err    (disp_err),
        .link_synced (link_synced),
        .align_cnt   (align_cnt),
        .disp_cnt    (disp_cnt)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int acnt(input int lane);
        return int'(align_cnt[lane*EW +: EW]);
    endfunction

    function automatic int dcnt(input int lane);
        return int'(disp_cnt[lane*EW +: EW]);
    endfunction

    function automatic logic [2*NL-1:0] all_phase(input logic [1:0] ph);
        logic [2*NL-1:0] v;
        for (int i = 0; i < NL; i++) v[2*i +: 2] = ph;
        return v;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; link_en = 1'b0; sw_reset = 1'b0;
        lane_phase = all_phase(2'd0); align_err = '0; disp_err = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R2 synced after reset", int'(link_synced), 0);
        for (int i = 0; i < NL; i++) begin
            check("R2 align cnt after reset", acnt(i), 0);
            check("R2 disp cnt after reset", dcnt(i), 0);
        end
    endtask

    task automatic t_qualify();
        link_en = 1'b1;
        tick(2);
        disp_err = 3'b001;
        align_err = 3'b001;
        tick(3);
        disp_err = '0; align_err = '0;
        check("R8 disparity counted in INIT", dcnt(0), 3);
        check("R8 align ignored outside DATA", acnt(0), 0);
        lane_phase = all_phase(2'd2);
        tick(QC - 1);
        check("R3 not synced one edge early", int'(link_synced), 0);
        tick(1);
        check("R3 synced after full run", int'(link_synced), 1);
        check("R7 disp cleared at lock", dcnt(0), 0);
    endtask

    task automatic t_restart();
        sw_reset = 1'b1;
        tick(1);
        check("R6 sw_reset drops sync", int'(link_synced), 0);
        sw_reset = 1'b0;
        tick(1);
        tick(100);
        lane_phase[3:2] = 2'd3;
        tick(1);
        lane_phase[3:2] = 2'd2;
        tick(QC - 1);
        check("R4 R1 code 3 restarts run", int'(link_synced), 0);
        tick(1);
        check("R4 synced after fresh run", int'(link_synced), 1);
    endtask

    task automatic t_locked();
        lane_phase = all_phase(2'd0);
        tick(20);
        check("R5 stays synced with lanes in INIT", int'(link_synced), 1);
        lane_phase = all_phase(2'd2);
        lane_phase[3:2] = 2'd1;
        align_err = 3'b110;
        tick(5);
        align_err = '0;
        check("R12 align errors kept after lock", acnt(2), 5);
        check("R8 align ignored on CHECK lane", acnt(1), 0);
        disp_err = 3'b010;
        tick(20);
        disp_err = '0;
        check("R10 disparity saturates", dcnt(1), 15);
        check("R5 still synced", int'(link_synced), 1);
    endtask

    task automatic t_disable();
        link_en = 1'b0;
        tick(1);
        check("R6 disable drops sync", int'(link_synced), 0);
        align_err = '1; disp_err = '1;
        tick(4);
        align_err = '0; disp_err = '0;
        check("R9 align frozen while disabled", acnt(2), 5);
        check("R9 disp frozen while disabled", dcnt(0), 0);
        check("R9 saturated disp frozen", dcnt(1), 15);
    endtask

    task automatic t_sw_clear();
        link_en = 1'b1;
        sw_reset = 1'b1;
        tick(1);
        sw_reset = 1'b0;
        check("R11 sw_reset clears align", acnt(2), 0);
        check("R11 sw_reset clears disp", dcnt(1), 0);
        check("R6 no sync after sw_reset", int'(link_synced), 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_qualify();
        t_restart();
        t_locked();
        t_disable();
        t_sw_clear();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule